// File: doc/BRIEF.md
# GPIO External Interrupt Selector

This block turns activity on a bank of 32 general-purpose input pins into interrupt events for five external interrupt channels. Channel slots 0 through 4 correspond to external interrupts 3 through 7. Each channel has a 5-bit runtime select that picks which pin of the bank it watches. A 16-bit control word per channel sets whether the channel is on and which edge polarity it reacts to.

The pin bank first passes through a shared two-flop synchronizer. Each channel then compares the synchronized level of its chosen pin with the level it saw on the previous cycle. When the enabled edge appears, the channel sets a sticky event flag.

The flag drives two outputs: a request to the interrupt expander and a trigger to the DMA request logic. The flag stays set until either downstream consumer returns a one-cycle acknowledge. If a new qualifying edge arrives in the same cycle as an acknowledge, the new edge wins.

Top module: `ext_irq_selector`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, every bit of `irq_req` and `dma_req` is 0.
- R2: After a pin level change that is driven between clock edges, the matching request rises on the third rising clock edge that follows. It is still low after the second edge.
- R3: Control bit 0 enables a channel. With the bit at 0, edges on the selected pin never set that channel's request.
- R4: Control bits 3:2 choose the edge. 2'b00 and 2'b10 react to a falling edge (1 to 0), 2'b01 reacts to a rising edge (0 to 1), and 2'b11 reacts to both. An edge of the other polarity sets nothing.
- R5: A channel watches only `pins[sel]`, where `sel` is the channel's 5-bit field. Edges on any other pin do not set its request.
- R6: In the cycle where a channel's select value differs from its value on the previous cycle, no event is detected. A level difference between the old pin and the new pin is therefore never taken as an edge.
- R7: Once set, a request stays high until `irq_ack` or `dma_ack` for that channel is sampled high. The request is low after that clock edge.
- R8: When an acknowledge and a new qualifying edge fall in the same cycle, the request remains set.
- R9: For each channel, `irq_req` and `dma_req` carry the same latched event.
- R10: Channel i takes its select from `sel_flat[5*i+4:5*i]` and its control from `ctrl_flat[16*i+15:16*i]`. Channels do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins | input | 32 | Asynchronous general-purpose input bank (pins 32..63 of the chip) |
| sel_flat | input | 25 | Five 5-bit pin selects, channel 0 in the low bits |
| ctrl_flat | input | 80 | Five 16-bit control words, channel 0 in the low bits |
| irq_ack | input | 5 | Per-channel acknowledge from the interrupt expander |
| dma_ack | input | 5 | Per-channel acknowledge from the DMA request logic |
| irq_req | output | 5 | Latched event to the interrupt expander |
| dma_req | output | 5 | Latched event as DMA trigger |

## Verification
The bench drives an acknowledge in exactly the cycle where a fresh edge is being detected. A design that lets the clear take priority would drop that second event. The bench also switches a channel's select from a low pin to a high pin. A design that does not mask the switch cycle would report a rising edge that never happened on any pin. Each polarity code is tried against both edge directions, including the duplicate falling code 2'b10, to catch a decoder that treats that code as rising or as both edges. The exact synchronizer latency is checked on both sides, and edges on unselected pins are driven to expose a wrong field slice or wrong pin index.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    localparam int NUM_CH = 5;
    localparam int PIN_W  = 32;
    localparam int CTRL_W = 16;

    typedef enum logic [1:0] {
        EDGE_FALL     = 2'b00,
        EDGE_RISE     = 2'b01,
        EDGE_FALL_ALT = 2'b10,
        EDGE_ANY      = 2'b11
    } edge_mode_e;

    typedef struct packed {
        logic [11:0] spare;
        edge_mode_e  mode;
        logic        spare1;
        logic        enable;
    } chan_ctrl_t;

    function automatic logic edge_match(edge_mode_e mode, logic prev, logic cur);
        logic rise;
        logic fall;
        rise = !prev && cur;
        fall = prev && !cur;
        case (mode)
            EDGE_RISE: edge_match = rise;
            EDGE_ANY:  edge_match = rise || fall;
            default:   edge_match = fall;
        endcase
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/chan_unit.sv
module chan_unit
    import ext_irq_pkg::*;
#(
    parameter int PIN_W = 32,
    localparam int SEL_W = $clog2(PIN_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIN_W-1:0] pins_s,
    input  logic [SEL_W-1:0] sel,
    input  logic             enable,
    input  edge_mode_e       mode,
    input  logic             irq_ack,
    input  logic             dma_ack,
    output logic             event_q
);
    logic             cur;
    logic             prev_q;
    logic [SEL_W-1:0] sel_q;
    logic             sel_chg;
    logic             hit;
    logic             ack;

    assign cur     = pins_s[sel];
    assign sel_chg = (sel != sel_q);
    assign hit     = enable && !sel_chg && edge_match(mode, prev_q, cur);
    assign ack     = irq_ack || dma_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            sel_q   <= '0;
            event_q <= 1'b0;
        end else begin
            prev_q <= cur;
            sel_q  <= sel;
            if (hit)
                event_q <= 1'b1;
            else if (ack)
                event_q <= 1'b0;
        end
    end

    // R3: a new event needs the enable bit in the detecting cycle
    a_r3_rise_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(event_q) |-> $past(enable));

    // R6: a select switch cycle never produces a new event
    a_r6_sel_switch_quiet: assert property (@(posedge clk) disable iff (rst)
        sel_chg |=> !$rose(event_q));

    // R7: acknowledge without a competing edge clears the flag
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ack && !hit) |=> !event_q);

    // R8: a detected edge always leaves the flag set
    a_r8_edge_wins: assert property (@(posedge clk) disable iff (rst)
        hit |=> event_q);

endmodule

// File: rtl/ext_irq_selector.sv
module ext_irq_selector
    import ext_irq_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    parameter int N_PIN = PIN_W,
    localparam int SEL_W = $clog2(N_PIN)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_PIN-1:0]        pins,
    input  logic [N_CH*SEL_W-1:0]   sel_flat,
    input  logic [N_CH*CTRL_W-1:0]  ctrl_flat,
    input  logic [N_CH-1:0]         irq_ack,
    input  logic [N_CH-1:0]         dma_ack,
    output logic [N_CH-1:0]         irq_req,
    output logic [N_CH-1:0]         dma_req
);
    logic [N_PIN-1:0] pins_s;
    logic [N_CH-1:0]  evt;
    logic [N_CH-1:0]  unused_spare_bits;

    pin_sync #(.WIDTH(N_PIN)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins),
        .q   (pins_s)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        chan_ctrl_t ctrl_i;
        assign ctrl_i = chan_ctrl_t'(ctrl_flat[i*CTRL_W +: CTRL_W]);
        assign unused_spare_bits[i] = ^{ctrl_i.spare, ctrl_i.spare1};

        chan_unit #(.PIN_W(N_PIN)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .pins_s  (pins_s),
            .sel     (sel_flat[i*SEL_W +: SEL_W]),
            .enable  (ctrl_i.enable),
            .mode    (ctrl_i.mode),
            .irq_ack (irq_ack[i]),
            .dma_ack (dma_ack[i]),
            .event_q (evt[i])
        );
    end

    assign irq_req = evt;
    assign dma_req = evt;

    // R1: outputs are clear on the first cycle after reset
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (irq_req == '0 && dma_req == '0));

endmodule

// File: tb/tb_ext_irq_selector.sv
module tb_ext_irq_selector;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] pins;
    logic [24:0] sel_flat;
    logic [79:0] ctrl_flat;
    logic [4:0]  irq_ack;
    logic [4:0]  dma_ack;
    logic [4:0]  irq_req;
    logic [4:0]  dma_req;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    ext_irq_selector dut (
        .clk(clk), .rst(rst), .pins(pins), .sel_flat(sel_flat),
        .ctrl_flat(ctrl_flat), .irq_ack(irq_ack), .dma_ack(dma_ack),
        .irq_req(irq_req), .dma_req(dma_req)
    );

    // entry: {ch[2:0], sel[4:0], en, mode[1:0], lvl0, lvl1, exp}
    localparam logic [13:0] VEC [11] = '{
        {3'd0, 5'd0,  1'b1, 2'b01, 1'b0, 1'b1, 1'b1},
        {3'd0, 5'd0,  1'b1, 2'b01, 1'b1, 1'b0, 1'b0},
        {3'd1, 5'd7,  1'b1, 2'b00, 1'b1, 1'b0, 1'b1},
        {3'd1, 5'd7,  1'b1, 2'b00, 1'b0, 1'b1, 1'b0},
        {3'd2, 5'd31, 1'b1, 2'b10, 1'b1, 1'b0, 1'b1},
        {3'd2, 5'd31, 1'b1, 2'b10, 1'b0, 1'b1, 1'b0},
        {3'd3, 5'd15, 1'b1, 2'b11, 1'b0, 1'b1, 1'b1},
        {3'd3, 5'd15, 1'b1, 2'b11, 1'b1, 1'b0, 1'b1},
        {3'd4, 5'd20, 1'b0, 2'b11, 1'b0, 1'b1, 1'b0},
        {3'd4, 5'd20, 1'b1, 2'b11, 1'b0, 1'b1, 1'b1},
        {3'd4, 5'd3,  1'b1, 2'b01, 1'b0, 1'b0, 1'b0}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        irq_ack = 5'h1f;
        tick();
        irq_ack = 5'h00;
        tick();
    endtask

    task automatic cfg(int ch, logic [4:0] s, logic en, logic [1:0] md);
        ctrl_flat = '0;
        ctrl_flat[ch*16 +: 16] = {12'h0, md, 1'b0, en};
        sel_flat[ch*5 +: 5] = s;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; pins = '0; sel_flat = '0; ctrl_flat = '0;
        irq_ack = '0; dma_ack = '0;
        @(negedge clk);
        check("R1 irq in reset", irq_req, 5'h0);
        tick(); tick();
        rst = 1'b0;
        tick();
        check("R1 irq after reset", irq_req, 5'h0);
        check("R1 dma after reset", dma_req, 5'h0);

        // table of vectors: R2 R3 R4 R9 R10
        for (int k = 0; k < 11; k++) begin
            logic [2:0] ch; logic [4:0] s; logic en; logic [1:0] md;
            logic l0; logic l1; logic ex;
            logic [4:0] expv;
            {ch, s, en, md, l0, l1, ex} = VEC[k];
            pins = '0;
            cfg(int'(ch), s, en, md);
            pins[s] = l0;
            repeat (5) tick();
            clear_all();
            check("R7 cleared before vector", irq_req, 5'h0);
            pins[s] = l1;
            tick(); tick();
            check("R2 not yet after two edges", irq_req, 5'h0);
            tick();
            expv = '0;
            expv[ch] = ex;
            check("R4/R3/R10 irq vector", irq_req, expv);
            check("R9 dma matches", dma_req, expv);
        end

        // R5: unselected pin ignored
        pins = '0;
        cfg(0, 5'd5, 1'b1, 2'b01);
        repeat (4) tick();
        clear_all();
        pins[6] = 1'b1;
        repeat (4) tick();
        check("R5 other pin ignored", irq_req, 5'h0);
        pins[5] = 1'b1;
        repeat (3) tick();
        check("R5 selected pin seen", irq_req, 5'h01);

        // R6: select switch low pin -> high pin
        pins = '0;
        pins[11] = 1'b1;
        cfg(0, 5'd10, 1'b1, 2'b01);
        repeat (4) tick();
        clear_all();
        sel_flat[4:0] = 5'd11;
        repeat (4) tick();
        check("R6 select switch no event", irq_req, 5'h0);

        // R7: hold then dma_ack clears
        pins = '0;
        cfg(1, 5'd2, 1'b1, 2'b01);
        repeat (4) tick();
        clear_all();
        pins[2] = 1'b1;
        repeat (3) tick();
        repeat (6) tick();
        check("R7 held without ack", dma_req, 5'h02);
        dma_ack = 5'h02;
        tick();
        dma_ack = 5'h00;
        check("R7 dma_ack clears", irq_req, 5'h00);

        // R8: ack coincides with new edge
        pins = '0;
        cfg(2, 5'd9, 1'b1, 2'b11);
        repeat (4) tick();
        clear_all();
        pins[9] = 1'b1;
        repeat (3) tick();
        check("R8 first event set", irq_req, 5'h04);
        pins[9] = 1'b0;
        tick(); tick();
        irq_ack = 5'h04;
        tick();
        irq_ack = 5'h00;
        check("R8 edge wins over ack", irq_req, 5'h04);
        tick();
        check("R8 still held", dma_req, 5'h04);
        irq_ack = 5'h04;
        tick();
        irq_ack = 5'h00;
        check("R7 irq_ack clears", irq_req, 5'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule